// File: doc/BRIEF.md
# Wishbone Master Transfer Engine

This block is the downstream half of a bus bridge. Transfer descriptors wait in a queue upstream; each one carries a byte address, byte enables, a burst flag with a beat count, and a direction. The engine takes the descriptor at the head of the queue and runs classic Wishbone cycles for it, one beat after another. Write data is taken from the head of a write-data FIFO. Each read beat produces one entry for a read FIFO, made of the returned word and an error flag. The queues themselves live outside the block and appear here only as empty flags, head values and pop strobes.

A slave may answer a strobe with acknowledge, retry or error. If it gives no answer at all, a watchdog ends the cycle after a set number of clocks. A retry costs one idle cycle and the same beat is then issued again. A failed write freezes the engine. Each failed write also produces a status record that holds the untranslated address and the failed word. The engine then waits for a command. On continue, it issues the failed word again. On abort, it throws away the rest of that descriptor's write data without touching the bus. A fixed offset, added or subtracted as a parameter selects, turns every upstream address into a bus address.

Top module: `wb_xfer_engine`

## Requirements
- R1: While idle with a non-empty descriptor queue, the engine starts the transfer on the next clock. A read raises cyc and stb in that cycle. A write raises them as soon as write data is present.
- R2: A retry response lowers cyc and stb for exactly one cycle. The same beat is then reissued with the same address, select and data.
- R3: An error response on a write stalls the engine with cyc low and no pops until a command arrives. Continue (cmd_continue high) reissues the failed word at the same address.
- R4: Abort (cmd_abort high during the stall; abort wins if both commands are high) pops the failed word and every remaining beat of the descriptor from the write FIFO, one per cycle while data is present, with cyc low. On the last of these pops it pops the descriptor.
- R5: Each read beat pushes one read-FIFO entry. On acknowledge the entry is wb_dat_i with rf_err=0. On error or timeout it is 0 with rf_err=1, and the burst goes on to the next beat.
- R6: wb_sel_o equals the descriptor byte enables for a single transfer (dq_burst=0) and is all ones for a burst.
- R7: The bus address of beat k is dq_addr + k*(DW/8), plus ADR_OFFSET when OFFSET_SUB=0 and minus ADR_OFFSET when OFFSET_SUB=1.
- R8: A failed write beat pulses st_valid for one cycle, with st_addr set to the untranslated beat address and st_data set to the failed word.
- R9: After TIMEOUT consecutive strobe cycles with no acknowledge, error or retry, the engine ends the beat as an error, in that TIMEOUT-th cycle.
- R10: Beats complete on acknowledge. The descriptor is popped in the cycle of its last completion, cyc and stb are low in the following cycle, and the next descriptor starts one cycle after that.
- R11: cmd_continue and cmd_abort have no effect when the engine is not stalled.
- R12: During a write whose data FIFO is empty, cyc and stb stay low and no response is consumed.
- R13: A burst descriptor with a beat count of 0 is run as one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dq_empty | input | 1 | Descriptor queue empty |
| dq_addr | input | AW | Head descriptor byte address |
| dq_be | input | DW/8 | Head descriptor byte enables |
| dq_burst | input | 1 | Head descriptor is a burst |
| dq_len | input | LENW | Burst beat count |
| dq_write | input | 1 | Head descriptor is a write |
| dq_pop | output | 1 | Remove head descriptor |
| wf_empty | input | 1 | Write-data FIFO empty |
| wf_data | input | DW | Write-data FIFO head |
| wf_pop | output | 1 | Remove write-data head |
| rf_push | output | 1 | Push read result |
| rf_data | output | DW | Read result word |
| rf_err | output | 1 | Read result error flag |
| cmd_continue | input | 1 | Resume a stalled write |
| cmd_abort | input | 1 | Drop a stalled write |
| st_valid | output | 1 | Write failure record valid |
| st_addr | output | AW | Untranslated address of failed word |
| st_data | output | DW | Failed write word |
| wb_adr_o | output | AW | Bus address |
| wb_dat_o | output | DW | Bus write data |
| wb_sel_o | output | DW/8 | Bus byte selects |
| wb_we_o | output | 1 | Bus write enable |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_dat_i | input | DW | Bus read data |
| wb_ack_i | input | 1 | Slave acknowledge |
| wb_err_i | input | 1 | Slave error |
| wb_rty_i | input | 1 | Slave retry |

## Verification
The bench checks that an abort drains exactly the failed word and the rest of its descriptor. A drain that stops one entry short would leave a stray word that the next write then sends to the wrong address. It also checks that continue reissues the failed word rather than skipping it, that a retry costs exactly one idle cycle, and that the watchdog fires in the fourth silent cycle; an off-by-one counter would shift each of these by a cycle. It also covers a read error in the middle of a burst, which must not end the burst, the subtracted offset, the burst select override, a zero-length burst, stray commands while idle, and a write that waits for its data.

// File: rtl/wb_xfer_engine.sv
module wb_xfer_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LENW = 4,
  parameter int TIMEOUT = 16,
  parameter logic [AW-1:0] ADR_OFFSET = '0,
  parameter bit OFFSET_SUB = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dq_empty,
  input  logic [AW-1:0]   dq_addr,
  input  logic [DW/8-1:0] dq_be,
  input  logic            dq_burst,
  input  logic [LENW-1:0] dq_len,
  input  logic            dq_write,
  output logic            dq_pop,
  input  logic            wf_empty,
  input  logic [DW-1:0]   wf_data,
  output logic            wf_pop,
  output logic            rf_push,
  output logic [DW-1:0]   rf_data,
  output logic            rf_err,
  input  logic            cmd_continue,
  input  logic            cmd_abort,
  output logic            st_valid,
  output logic [AW-1:0]   st_addr,
  output logic [DW-1:0]   st_data,
  output logic [AW-1:0]   wb_adr_o,
  output logic [DW-1:0]   wb_dat_o,
  output logic [DW/8-1:0] wb_sel_o,
  output logic            wb_we_o,
  output logic            wb_cyc_o,
  output logic            wb_stb_o,
  input  logic [DW-1:0]   wb_dat_i,
  input  logic            wb_ack_i,
  input  logic            wb_err_i,
  input  logic            wb_rty_i
);
  localparam int SW  = DW / 8;
  localparam int BSH = $clog2(SW);
  localparam int TW  = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_WRTY, S_RRTY, S_STALL} state_t;

  state_t          state;
  logic [LENW-1:0] beat;
  logic            drain;
  logic [TW-1:0]   tcnt;

  logic [LENW-1:0] beats;
  logic            last, bus_on, quiet, tmo, fail, retry, ok, drain_step, step;
  logic [AW-1:0]   byte_addr;

  assign beats      = (dq_burst && dq_len != '0) ? dq_len : LENW'(1);
  assign last       = (beat == beats - LENW'(1));
  assign bus_on     = (state == S_WR && !drain && !wf_empty) || state == S_RD;
  assign quiet      = !(wb_ack_i || wb_err_i || wb_rty_i);
  assign tmo        = bus_on && quiet && tcnt == TW'(TIMEOUT - 1);
  assign fail       = bus_on && (wb_err_i || tmo);
  assign retry      = bus_on && wb_rty_i && !wb_err_i;
  assign ok         = bus_on && wb_ack_i && !wb_err_i && !wb_rty_i;
  assign drain_step = state == S_WR && drain && !wf_empty;
  assign step       = (state == S_WR && (ok || drain_step)) || (state == S_RD && (ok || fail));

  assign byte_addr = dq_addr + (AW'(beat) << BSH);

  assign wb_cyc_o = bus_on;
  assign wb_stb_o = bus_on;
  assign wb_we_o  = (state == S_WR);
  assign wb_adr_o = OFFSET_SUB ? byte_addr - ADR_OFFSET : byte_addr + ADR_OFFSET;
  assign wb_sel_o = dq_burst ? {SW{1'b1}} : dq_be;
  assign wb_dat_o = wf_data;

  assign dq_pop  = step && last;
  assign wf_pop  = state == S_WR && (ok || drain_step);
  assign rf_push = state == S_RD && (ok || fail);
  assign rf_err  = fail;
  assign rf_data = ok ? wb_dat_i : '0;

  assign st_valid = state == S_WR && fail;
  assign st_addr  = byte_addr;
  assign st_data  = wf_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      beat  <= '0;
      drain <= 1'b0;
      tcnt  <= '0;
    end else begin
      tcnt <= (bus_on && quiet && !tmo) ? tcnt + TW'(1) : '0;
      case (state)
        S_IDLE: if (!dq_empty) begin
          state <= dq_write ? S_WR : S_RD;
          beat  <= '0;
          drain <= 1'b0;
        end
        S_WR: begin
          if (fail) state <= S_STALL;
          else if (retry) state <= S_WRTY;
          else if (step) begin
            if (last) begin
              state <= S_IDLE;
              drain <= 1'b0;
            end else beat <= beat + LENW'(1);
          end
        end
        S_RD: begin
          if (retry) state <= S_RRTY;
          else if (step) begin
            if (last) state <= S_IDLE;
            else beat <= beat + LENW'(1);
          end
        end
        S_WRTY: state <= S_WR;
        S_RRTY: state <= S_RD;
        S_STALL: begin
          if (cmd_abort) begin
            state <= S_WR;
            drain <= 1'b1;
          end else if (cmd_continue) state <= S_WR;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_retry_gap_R2: assert property (@(posedge clk) disable iff (rst)
    retry |=> !wb_cyc_o) else $error("retry gap");

  assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_STALL) |-> (!wb_cyc_o && !wf_pop && !dq_pop)) else $error("stall activity");

  assert_drain_no_bus_R4: assert property (@(posedge clk) disable iff (rst)
    wf_pop && !wb_cyc_o |-> drain) else $error("pop without bus");

  assert_read_side_R5: assert property (@(posedge clk) disable iff (rst)
    rf_push |-> (wb_cyc_o && !wb_we_o)) else $error("read push outside read");

  assert_status_write_R8: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> !wb_cyc_o) else $error("status without stall");

  assert_watchdog_bound_R9: assert property (@(posedge clk) disable iff (rst)
    tcnt < TW'(TIMEOUT)) else $error("watchdog overrun");

  assert_pop_gap_R10: assert property (@(posedge clk) disable iff (rst)
    dq_pop |=> !wb_cyc_o) else $error("no gap after descriptor");
endmodule

// File: tb/sim_wb_xfer_engine.sv
module sim_wb_xfer_engine;
  localparam int AW = 32, DW = 32, LENW = 4, TO = 4;
  localparam logic [31:0] OFS = 32'h100;

  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic dq_empty, dq_burst, dq_write, wf_empty, cmd_continue, cmd_abort;
  logic [31:0] dq_addr, wf_data;
  logic [3:0] dq_be, dq_len;
  int rsp_cur;
  logic dq_pop, wf_pop, rf_push, rf_err, st_valid, wb_we_o, wb_cyc_o, wb_stb_o;
  logic [31:0] rf_data, st_addr, st_data, wb_adr_o, wb_dat_o, wb_dat_i;
  logic [3:0] wb_sel_o;
  logic wb_ack_i, wb_err_i, wb_rty_i;

  assign wb_ack_i = wb_stb_o && rsp_cur == 1;
  assign wb_err_i = wb_stb_o && rsp_cur == 2;
  assign wb_rty_i = wb_stb_o && rsp_cur == 3;
  assign wb_dat_i = wb_adr_o ^ 32'hA5A5_0000;

  wb_xfer_engine #(.AW(AW), .DW(DW), .LENW(LENW), .TIMEOUT(TO),
                   .ADR_OFFSET(OFS), .OFFSET_SUB(1'b1)) u0 (
    .clk(clk), .rst(rst), .dq_empty(dq_empty), .dq_addr(dq_addr), .dq_be(dq_be),
    .dq_burst(dq_burst), .dq_len(dq_len), .dq_write(dq_write), .dq_pop(dq_pop),
    .wf_empty(wf_empty), .wf_data(wf_data), .wf_pop(wf_pop), .rf_push(rf_push),
    .rf_data(rf_data), .rf_err(rf_err), .cmd_continue(cmd_continue), .cmd_abort(cmd_abort),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .wb_adr_o(wb_adr_o),
    .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o), .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o),
    .wb_stb_o(wb_stb_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i),
    .wb_rty_i(wb_rty_i));

  logic [31:0] qa[$];
  logic [3:0]  qbe[$], ql[$];
  bit          qb[$], qw[$];
  logic [31:0] wfq[$];
  int          rsp[$];

  int checks = 0, errors = 0;

  // reference model: phase 0 idle, 1 write, 2 read, 3 write retry, 4 read retry, 5 stalled
  int ph, beat, tc, nb;
  bit drn;
  bit act, tmo, fail, retry, okk, dstep, step, lastb, exp_cyc;
  bit e_fail, e_retry, e_step, e_last, e_act, e_quiet, e_tmo;
  bit r_dqpop, r_wfpop, r_stb;
  int code;
  logic [31:0] badr;
  string tagc;

  task automatic refresh();
    dq_empty = (qa.size() == 0);
    dq_addr  = dq_empty ? '0 : qa[0];
    dq_be    = dq_empty ? '0 : qbe[0];
    dq_burst = dq_empty ? 1'b0 : qb[0];
    dq_len   = dq_empty ? '0 : ql[0];
    dq_write = dq_empty ? 1'b0 : qw[0];
    wf_empty = (wfq.size() == 0);
    wf_data  = wf_empty ? '0 : wfq[0];
    rsp_cur  = (rsp.size() == 0) ? 1 : rsp[0];
  endtask

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      nb    = (qa.size() == 0) ? 1 : ((qb[0] && ql[0] != 0) ? int'(ql[0]) : 1); // R13
      lastb = (beat == nb - 1);
      act   = (ph == 1 && !drn && wfq.size() != 0) || ph == 2;
      code  = act ? rsp_cur : 0;
      tmo   = act && code == 0 && tc == TO - 1;
      fail  = act && (code == 2 || tmo);
      retry = act && code == 3;
      okk   = act && code == 1;
      dstep = ph == 1 && drn && wfq.size() != 0;
      step  = (ph == 1 && (okk || dstep)) || (ph == 2 && (okk || fail));
      exp_cyc = act;
      badr  = (qa.size() == 0) ? 32'h0 : qa[0] + 32'(beat * 4);
      if (ph == 0) tagc = (cmd_abort || cmd_continue) ? "R11 cyc" : "R1 cyc";
      else if (ph == 3 || ph == 4) tagc = "R2 cyc";
      else if (ph == 5) tagc = "R3 cyc";
      else if (drn) tagc = "R4 cyc";
      else if (ph == 1 && wfq.size() == 0) tagc = "R12 cyc";
      else tagc = "R10 cyc";
      chk(tagc, wb_cyc_o, exp_cyc);
      chk(tagc, wb_stb_o, exp_cyc);
      if (exp_cyc) begin
        chk("R7 address", wb_adr_o, badr - OFS);
        chk("R6 select", wb_sel_o, qb[0] ? 4'hF : qbe[0]);
        chk("R10 direction", wb_we_o, ph == 1);
        if (ph == 1) chk("R3 write data", wb_dat_o, wfq[0]);
      end
      chk("R10 dq_pop", dq_pop, step && lastb);
      chk(drn ? "R4 wf_pop" : "R10 wf_pop", wf_pop, ph == 1 && (okk || dstep));
      chk("R5 rf_push", rf_push, ph == 2 && (okk || fail));
      if (ph == 2 && (okk || fail)) begin
        chk(tmo ? "R9 rf_err" : "R5 rf_err", rf_err, fail);
        chk("R5 rf_data", rf_data, okk ? ((badr - OFS) ^ 32'hA5A5_0000) : 32'h0);
      end
      chk(tmo ? "R9 st_valid" : "R8 st_valid", st_valid, ph == 1 && fail);
      if (ph == 1 && fail) begin
        chk("R8 st_addr", st_addr, badr);
        chk("R8 st_data", st_data, wfq[0]);
      end
      e_fail = fail; e_retry = retry; e_step = step; e_last = lastb;
      e_act = act; e_quiet = (code == 0); e_tmo = tmo;
      r_dqpop = dq_pop; r_wfpop = wf_pop; r_stb = wb_stb_o;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; beat = 0; drn = 0; tc = 0;
      e_fail = 0; e_retry = 0; e_step = 0; e_last = 0; e_act = 0; e_quiet = 0; e_tmo = 0;
      r_dqpop = 0; r_wfpop = 0; r_stb = 0;
    end else begin
      tc = (e_act && e_quiet && !e_tmo) ? tc + 1 : 0;
      case (ph)
        0: if (qa.size() != 0) begin ph = qw[0] ? 1 : 2; beat = 0; drn = 0; end
        1: if (e_fail) ph = 5;
           else if (e_retry) ph = 3;
           else if (e_step) begin
             if (e_last) begin ph = 0; drn = 0; end else beat++;
           end
        2: if (e_retry) ph = 4;
           else if (e_step) begin
             if (e_last) ph = 0; else beat++;
           end
        3: ph = 1;
        4: ph = 2;
        5: if (cmd_abort) begin ph = 1; drn = 1; end
           else if (cmd_continue) ph = 1;
        default: ph = 0;
      endcase
      if (r_dqpop && qa.size() != 0) begin
        void'(qa.pop_front()); void'(qbe.pop_front()); void'(qb.pop_front());
        void'(ql.pop_front()); void'(qw.pop_front());
      end
      if (r_wfpop && wfq.size() != 0) void'(wfq.pop_front());
      if (r_stb && rsp.size() != 0) void'(rsp.pop_front());
      r_dqpop = 0; r_wfpop = 0; r_stb = 0;
      e_fail = 0; e_retry = 0; e_step = 0; e_act = 0; e_quiet = 0; e_tmo = 0;
    end
    #1 refresh();
  end

  task automatic add_desc(input logic [31:0] a, input logic [3:0] be, input bit b,
                          input logic [3:0] l, input bit w);
    qa.push_back(a); qbe.push_back(be); qb.push_back(b); ql.push_back(l); qw.push_back(w);
    refresh();
  endtask

  task automatic add_wd(input logic [31:0] d);
    wfq.push_back(d); refresh();
  endtask

  task automatic add_rsp(input int c);
    rsp.push_back(c); refresh();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (qa.size() == 0 && ph == 0) break;
    end
  endtask

  task automatic wait_stall();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ph == 5) break;
    end
  endtask

  task automatic pulse_cmd(input bit abrt);
    @(negedge clk);
    if (abrt) cmd_abort = 1; else cmd_continue = 1;
    @(negedge clk);
    cmd_abort = 0; cmd_continue = 0;
  endtask

  int cyc_count = 0;
  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cmd_abort = 0; cmd_continue = 0;
    refresh();
    repeat (3) @(negedge clk);
    #2;
    // R1 R10: outputs quiet under reset
    chk("R1 reset cyc", wb_cyc_o, 0);
    chk("R10 reset dq_pop", dq_pop, 0);
    chk("R4 reset wf_pop", wf_pop, 0);
    chk("R5 reset rf_push", rf_push, 0);
    chk("R8 reset st_valid", st_valid, 0);
    @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R11: stray commands while idle, then a normal single write
    pulse_cmd(1'b1);
    pulse_cmd(1'b0);
    add_wd(32'h1111_2222);
    add_desc(32'h0000_1000, 4'b0011, 0, 0, 1);
    wait_idle();

    // R1 R6 R7: single read with byte enables
    add_desc(32'h0000_2004, 4'b1100, 0, 0, 0);
    wait_idle();

    // R10: burst write of four with wait states
    add_rsp(0); add_rsp(1); add_rsp(1); add_rsp(0); add_rsp(0); add_rsp(1); add_rsp(1);
    for (int i = 0; i < 4; i++) add_wd(32'hB000_0000 + i);
    add_desc(32'h0000_3000, 4'b0001, 1, 4, 1);
    wait_idle();

    // R5: burst read of three, error on middle beat
    add_rsp(1); add_rsp(2); add_rsp(1);
    add_desc(32'h0000_4000, 4'b0000, 1, 3, 0);
    wait_idle();

    // R2: retry on a write and on a read
    add_rsp(3); add_rsp(1);
    add_wd(32'hCAFE_0001);
    add_desc(32'h0000_5000, 4'b1111, 0, 0, 1);
    wait_idle();
    add_rsp(0); add_rsp(3); add_rsp(1);
    add_desc(32'h0000_5100, 4'b0110, 0, 0, 0);
    wait_idle();

    // R3 R8: error on beat 1 of a burst write, then continue
    add_rsp(1); add_rsp(2);
    for (int i = 0; i < 3; i++) add_wd(32'hD000_0000 + i);
    add_desc(32'h0000_6000, 4'b0001, 1, 3, 1);
    wait_stall();
    repeat (3) @(negedge clk);
    pulse_cmd(1'b0);
    wait_idle();

    // R4: error on beat 1 of four, abort drains the rest, then recovery
    add_rsp(1); add_rsp(2);
    for (int i = 0; i < 4; i++) add_wd(32'hE000_0000 + i);
    add_desc(32'h0000_7000, 4'b0001, 1, 4, 1);
    wait_stall();
    repeat (2) @(negedge clk);
    pulse_cmd(1'b1);
    wait_idle();
    chk("R4 write FIFO drained", wfq.size(), 0);
    add_wd(32'h7777_0000);
    add_desc(32'h0000_7100, 4'b1000, 0, 0, 1);
    wait_idle();

    // R9: watchdog on a write (status record) and on a read burst
    add_rsp(0); add_rsp(0); add_rsp(0); add_rsp(0);
    add_wd(32'h9999_0001);
    add_desc(32'h0000_8000, 4'b0101, 0, 0, 1);
    wait_stall();
    pulse_cmd(1'b0);
    wait_idle();
    add_rsp(0); add_rsp(0); add_rsp(0); add_rsp(0);
    add_desc(32'h0000_8100, 4'b0000, 1, 2, 0);
    wait_idle();

    // R12: write waits for data; R10: back-to-back descriptors; R13: zero-length burst
    add_desc(32'h0000_9000, 4'b0001, 0, 0, 1);
    repeat (4) @(negedge clk);
    add_wd(32'h5555_AAAA);
    wait_idle();
    add_desc(32'h0000_A000, 4'b0010, 0, 0, 0);
    add_desc(32'h0000_A100, 4'b0000, 1, 0, 0);
    add_wd(32'h1234_5678);
    add_desc(32'h0000_A200, 4'b0100, 1, 2, 1);
    add_wd(32'h8765_4321);
    wait_idle();
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule